// File: doc/BRIEF.md
# Iterative Integer Divider

This block divides a double-width or single-width dividend by a single-width divisor. It returns a single-width quotient and a single-width remainder. The divisor width is the parameter `W`, which defaults to 16. One control bit picks the operand size and another picks signed or unsigned arithmetic, which gives four combinations. All four run on the same shift-and-subtract datapath.

The datapath works on magnitudes. It resolves one quotient bit per divisor bit, so every operation takes exactly `W` iterations whatever its size or sign. Before the loop starts, a compare of the dividend's upper half against the divisor finds quotients too large for `W` bits, and this also catches a zero divisor. After the loop, a small fix-up stage restores the signs and checks the signed quotient range.

Control is a three-state machine:
- **IDLE**: waits for `start`. On IDLE→RUN it captures the operands.
- **RUN**: performs one iteration per clock. RUN→DONE happens after the `W`-th iteration.
- **DONE**: holds `done` for one cycle. DONE→IDLE follows unconditionally.

Results stay on the outputs until the next accepted start.

Top module: `iter_div`

## Requirements
- R1: With `wide`=1 the dividend is {`dvd_hi`,`dvd_lo`} (2W bits). With `wide`=0 it is `dvd_lo` alone, zero-extended when `sgn`=0 and sign-extended when `sgn`=1, and `dvd_hi` has no effect on any output.
- R2: With `sgn`=0 and no overflow, `quo` is the floor of dividend/divisor and `rem` is dividend − quo·divisor, which is always less than the divisor.
- R3: With `sgn`=1, operands and results are two's complement. The quotient truncates toward zero, and a nonzero remainder has the sign of the dividend.
- R4: A zero divisor sets `ovf` in every mode.
- R5: `ovf` is set when the true quotient lies outside 0..2^W−1 (unsigned) or outside −2^(W−1)..2^(W−1)−1 (signed), including the most negative dividend divided by −1. `quo` and `rem` are then unspecified.
- R6: `done` is high for exactly one cycle. That cycle begins W clock edges after the edge that accepted `start`, for all four modes.
- R7: `busy` is high from the cycle after acceptance through the `done` cycle. A `start` seen while `busy` is high is ignored: the operation in flight completes with its own operands and no new operation begins.
- R8: `quo`, `rem` and `ovf` hold their values from the `done` cycle until the next accepted `start`, even if the operand inputs change.
- R9: During and after reset, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a division; taken only while idle |
| dvd_hi | input | W | Upper dividend word (double-width mode only) |
| dvd_lo | input | W | Lower dividend word |
| dvsr | input | W | Divisor |
| sgn | input | 1 | 1 = signed, 0 = unsigned |
| wide | input | 1 | 1 = 2W/W divide, 0 = W/W divide |
| busy | output | 1 | Operation in flight (RUN or DONE) |
| done | output | 1 | One-cycle completion pulse |
| quo | output | W | Quotient |
| rem | output | W | Remainder |
| ovf | output | 1 | Divide by zero or quotient out of range |

## Verification
A fault in the iteration counter shifts the `done` pulse away from the W-th edge. The bench measures the latency of every operation, so such a fault is seen on the first divide. A fault in a quotient or remainder register bit, or in the trial subtraction, shows as a wrong `quo` or `rem` at the very next `done`. The bench compares these against an arithmetic model over every operand combination of a 4-bit instance in all four modes. Sign fix-up and range faults show only for certain operand signs or magnitudes, and the exhaustive sweep reaches those corners within the same run.

// File: rtl/iter_div_pkg.sv
package iter_div_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } div_state_e;
endpackage

// File: rtl/div_prep.sv
module div_prep #(
    parameter int W = 16
) (
    input  logic [W-1:0]   dvd_hi,
    input  logic [W-1:0]   dvd_lo,
    input  logic [W-1:0]   dvsr,
    input  logic           sgn,
    input  logic           wide,
    output logic [2*W-1:0] num_mag,
    output logic [W-1:0]   den_mag,
    output logic           num_neg,
    output logic           den_neg,
    output logic           pre_ovf
);
    localparam int DW = 2 * W;

    logic          ext_bit;
    logic [DW-1:0] num;

    always_comb begin
        ext_bit = sgn & dvd_lo[W-1];
        num     = wide ? {dvd_hi, dvd_lo} : {{W{ext_bit}}, dvd_lo};
        num_neg = sgn & num[DW-1];
        den_neg = sgn & dvsr[W-1];
        num_mag = num_neg ? (~num + 1'b1) : num;
        den_mag = den_neg ? (~dvsr + 1'b1) : dvsr;
        // Upper half not below divisor: quotient needs more than W bits (or divisor is zero)
        pre_ovf = (num_mag[DW-1:W] >= den_mag);
    end
endmodule

// File: rtl/div_step.sv
module div_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] rem_in,
    input  logic [W-1:0] quo_in,
    input  logic [W-1:0] den,
    output logic [W-1:0] rem_out,
    output logic [W-1:0] quo_out
);
    logic [W:0] shifted;
    logic [W:0] trial;

    always_comb begin
        shifted = {rem_in, quo_in[W-1]};
        trial   = shifted - {1'b0, den};
        if (!trial[W]) begin
            rem_out = trial[W-1:0];
            quo_out = {quo_in[W-2:0], 1'b1};
        end else begin
            rem_out = shifted[W-1:0];
            quo_out = {quo_in[W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/div_fix.sv
module div_fix #(
    parameter int W = 16
) (
    input  logic [W-1:0] quo_mag,
    input  logic [W-1:0] rem_mag,
    input  logic         q_neg,
    input  logic         r_neg,
    input  logic         sgn,
    input  logic         pre_ovf,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem,
    output logic         ovf
);
    logic range_bad;

    always_comb begin
        quo = q_neg ? (~quo_mag + 1'b1) : quo_mag;
        rem = r_neg ? (~rem_mag + 1'b1) : rem_mag;
        if (q_neg) range_bad = quo_mag[W-1] & (|quo_mag[W-2:0]);
        else       range_bad = quo_mag[W-1];
        ovf = pre_ovf | (sgn & range_bad);
    end
endmodule

// File: rtl/iter_div.sv
module iter_div #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dvd_hi,
    input  logic [W-1:0] dvd_lo,
    input  logic [W-1:0] dvsr,
    input  logic         sgn,
    input  logic         wide,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem,
    output logic         ovf
);
    import iter_div_pkg::*;

    localparam int DW = 2 * W;
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam int KW = $clog2(W + 2) + 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    div_state_e state, state_nx;
    logic [CW-1:0] iter_q;
    logic [W-1:0]  rem_q, quo_q, den_q;
    logic          sgn_q, qneg_q, rneg_q, povf_q;
    logic          accept;

    logic [DW-1:0] p_num_mag;
    logic [W-1:0]  p_den_mag;
    logic          p_num_neg, p_den_neg, p_ovf;
    logic [W-1:0]  s_rem, s_quo;

    div_prep #(.W(W)) prep_i (
        .dvd_hi (dvd_hi),
        .dvd_lo (dvd_lo),
        .dvsr   (dvsr),
        .sgn    (sgn),
        .wide   (wide),
        .num_mag(p_num_mag),
        .den_mag(p_den_mag),
        .num_neg(p_num_neg),
        .den_neg(p_den_neg),
        .pre_ovf(p_ovf)
    );

    div_step #(.W(W)) step_i (
        .rem_in (rem_q),
        .quo_in (quo_q),
        .den    (den_q),
        .rem_out(s_rem),
        .quo_out(s_quo)
    );

    div_fix #(.W(W)) fix_i (
        .quo_mag(quo_q),
        .rem_mag(rem_q),
        .q_neg  (qneg_q),
        .r_neg  (rneg_q),
        .sgn    (sgn_q),
        .pre_ovf(povf_q),
        .quo    (quo),
        .rem    (rem),
        .ovf    (ovf)
    );

    assign accept = (state == ST_IDLE) && start;

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_RUN;
            ST_RUN:  if (iter_q == LAST) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Outputs
    always_comb begin
        busy = (state != ST_IDLE);
        done = (state == ST_DONE);
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iter_q <= '0;
            rem_q  <= '0;
            quo_q  <= '0;
            den_q  <= '0;
            sgn_q  <= 1'b0;
            qneg_q <= 1'b0;
            rneg_q <= 1'b0;
            povf_q <= 1'b0;
        end else if (accept) begin
            iter_q <= '0;
            rem_q  <= p_num_mag[DW-1:W];
            quo_q  <= p_num_mag[W-1:0];
            den_q  <= p_den_mag;
            sgn_q  <= sgn;
            qneg_q <= p_num_neg ^ p_den_neg;
            rneg_q <= p_num_neg;
            povf_q <= p_ovf;
        end else if (state == ST_RUN) begin
            iter_q <= iter_q + 1'b1;
            rem_q  <= s_rem;
            quo_q  <= s_quo;
        end
    end

    // Latency watch for the completion check
    logic [KW-1:0] chk_cyc;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     chk_cyc <= '0;
        else if (!busy) chk_cyc <= '0;
        else            chk_cyc <= chk_cyc + 1'b1;
    end

    AST_DONE_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) done |-> (chk_cyc == KW'(W))); // R6
    AST_START_TAKEN:  assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> (busy && !done)); // R7
    AST_BUSY_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) (busy && !done) |=> busy); // R7
    AST_RESULT_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> ($stable(quo) && $stable(rem) && $stable(ovf))); // R8
    AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n) (done && den_q == '0) |-> ovf); // R4
    AST_REM_BOUND:    assert property (@(posedge clk) disable iff (!rst_n) (done && !ovf) |-> (rem_q < den_q)); // R2
    AST_RESET_IDLE:   assert property (@(posedge clk) !rst_n |=> (!busy && !done)); // R9
endmodule

// File: tb/iter_div_tb_top.sv
module iter_div_tb_top;
    localparam int BW = 4;
    localparam longint ONE = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [BW-1:0] dvd_hi = '0, dvd_lo = '0, dvsr = '0;
    logic          sgn = 1'b0, wide = 1'b0;
    logic          busy, done, ovf;
    logic [BW-1:0] quo, rem;

    int tests = 0;
    int fails = 0;
    longint cycles = 0;

    iter_div #(.W(BW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .dvsr(dvsr),
        .sgn(sgn), .wide(wide),
        .busy(busy), .done(done), .quo(quo), .rem(rem), .ovf(ovf)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            fails = fails + 1;
            $display("FAIL watchdog actual=%0d expected=<190000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        tests = tests + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void model(input logic [BW-1:0] hi, lo, d, input bit sg, wd,
                                  output longint q, r, output bit ov);
        longint n, dv;
        if (wd) begin
            n = longint'({hi, lo});
            if (sg && hi[BW-1]) n = n - (ONE << (2*BW));
        end else begin
            n = longint'(lo);
            if (sg && lo[BW-1]) n = n - (ONE << BW);
        end
        dv = longint'(d);
        if (sg && d[BW-1]) dv = dv - (ONE << BW);
        if (dv == 0) begin
            ov = 1'b1; q = 0; r = 0;
        end else begin
            q = n / dv;
            r = n % dv;
            if (sg) ov = (q > (ONE << (BW-1)) - 1) || (q < -(ONE << (BW-1)));
            else    ov = (q > (ONE << BW) - 1);
        end
    endfunction

    task automatic run_op(input logic [BW-1:0] hi, lo, d, input bit sg, wd);
        longint eq, er;
        bit eo;
        int n;
        logic [BW-1:0] hq, hr;
        logic ho;
        string vtag;
        @(negedge clk);
        dvd_hi = hi; dvd_lo = lo; dvsr = d; sgn = sg; wide = wd; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < BW + 4) begin
            @(posedge clk); n++; @(negedge clk);
        end
        chk("R6 latency", n, BW);
        model(hi, lo, d, sg, wd, eq, er, eo);
        vtag = !wd ? "R1" : (sg ? "R3" : "R2");
        chk(d == 0 ? "R4 ovf" : "R5 ovf", longint'(ovf), longint'(eo));
        if (!eo) begin
            chk({vtag, " quo"}, longint'(quo), longint'(eq[BW-1:0]));
            chk({vtag, " rem"}, longint'(rem), longint'(er[BW-1:0]));
        end
        hq = quo; hr = rem; ho = ovf;
        dvd_hi = ~hi; dvd_lo = ~lo; dvsr = ~d; sgn = ~sg;
        @(posedge clk); @(negedge clk);
        chk("R6 done low", longint'(done), 0);
        chk("R7 idle", longint'(busy), 0);
        chk("R8 hold", longint'({hq, hr, ho}), longint'({quo, rem, ovf}));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk("R9 busy", longint'(busy), 0);
        chk("R9 done", longint'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 busy after", longint'(busy), 0);

        // Corners: most negative / -1 in both sizes, zero divisor
        run_op(4'h8, 4'h0, 4'hF, 1'b1, 1'b1); // R5
        run_op(4'h0, 4'h8, 4'hF, 1'b1, 1'b0); // R5
        run_op(4'h3, 4'h7, 4'h0, 1'b0, 1'b1); // R4

        // Start while busy is ignored (R7)
        begin
            int n;
            @(negedge clk);
            dvd_hi = 4'h3; dvd_lo = 4'hB; dvsr = 4'h5; sgn = 1'b0; wide = 1'b1; start = 1'b1;
            @(posedge clk); @(negedge clk);
            start = 1'b0;
            @(posedge clk); @(negedge clk);
            dvd_hi = 4'h1; dvd_lo = 4'h0; dvsr = 4'h3; start = 1'b1;
            @(posedge clk); @(negedge clk);
            start = 1'b0;
            chk("R7 busy held", longint'(busy), 1);
            n = 0;
            while (!done && n < BW + 4) begin
                @(posedge clk); n++; @(negedge clk);
            end
            chk("R7 first quo", longint'(quo), 11);
            chk("R7 first rem", longint'(rem), 4);
            @(posedge clk); @(negedge clk);
            chk("R7 no restart", longint'(busy), 0);
        end

        // Exhaustive sweep of the 4-bit instance in all four modes
        for (int sg = 0; sg < 2; sg++) begin
            for (int lo = 0; lo < 16; lo++) begin
                for (int d = 0; d < 16; d++) begin
                    run_op(BW'(lo ^ d ^ 5), BW'(lo), BW'(d), sg[0], 1'b0);
                end
            end
            for (int hi = 0; hi < 16; hi++) begin
                for (int lo = 0; lo < 16; lo++) begin
                    for (int d = 0; d < 16; d++) begin
                        run_op(BW'(hi), BW'(lo), BW'(d), sg[0], 1'b1);
                    end
                end
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule